// File: doc/BRIEF.md
# UART Configuration and Interrupt Register Bank

This block is the software-visible register bank of a serial port. It stores the interrupt enables, the receiver and transmitter enables, the frame-format settings and a 12-bit baud-rate divisor. It then presents all of these to the serial engines as plain configuration outputs. The block does not contain the engines. It takes their three status flags and the processor's global interrupt enable, and it returns three registered interrupt request lines.

The bank sits on a simple 8-bit bus. Writes are strobed by `wr_en` and land on the rising clock edge. Reads are combinational from `addr`. Four word addresses are decoded:

- Address 0 is the control register.
- Address 1 is shared between the format register and the upper divisor bits. On a write, data bit 7 selects the target. On a read, the `hi_sel` input selects the source. This models the two-step access that shared locations normally need.
- Address 2 is the lower divisor byte.
- Address 3 is unused.

The design is a register file, a read multiplexer and an interrupt stage. It has no sequencing, so it contains no state machine.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset, the outputs and reads are as follows. Address 0 reads 0x00 when `rx_bit8_in` is 0. Address 1 reads 0x86 with `hi_sel`=0 and 0x00 with `hi_sel`=1. Address 2 reads 0x00. All interrupt lines are 0. The configuration outputs are 8-bit characters (`char_size`=3'b011), asynchronous, no parity, one stop bit, divisor 0.
- R2: A write to address 0 stores data bits 7:2 and bit 0. Bit 7 is the receive-done enable, bit 6 the transmit-done enable, bit 5 the empty enable, bit 4 `rx_en`, bit 3 `tx_en`, bit 2 the high character-size bit and bit 0 `tx_bit8`. A read of address 0 returns bit 1 as the live `rx_bit8_in`. Written data bit 1 has no effect.
- R3: A write to address 1 with data bit 7 = 1 stores data bits 6:0 into the format register and leaves the divisor unchanged.
- R4: A write to address 1 with data bit 7 = 0 stores data bits 3:0 into divisor bits 11:8. Data bits 6:4 are discarded, and the format register is unchanged.
- R5: A read of address 1 behaves as follows. With `hi_sel`=0 it returns {1, format[6:0]}. With `hi_sel`=1 it returns {0, 3'b000, divisor[11:8]}.
- R6: A write to address 2 stores divisor bits 7:0, and a read of address 2 returns them.
- R7: `char_size` = {control bit 2, format bits 2:1}.
- R8: The format fields drive the outputs as follows: `sync_mode` = format bit 6, `parity_mode` = format bits 5:4, `stop2` = format bit 3, `clk_pol` = format bit 0. `baud_div` is the 12-bit divisor.
- R9: Each interrupt line is 1 exactly when its enable, `gie` and its status flag were all 1 at the previous rising edge. `irq_rx` pairs with `rx_done`, `irq_tx` with `tx_done`, and `irq_dre` with `dr_empty`.
- R10: Address 3 always reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| hi_sel | input | 1 | Shared-address read source: 1 = divisor high |
| rdata | output | 8 | Read data (combinational) |
| gie | input | 1 | Global interrupt enable |
| rx_done | input | 1 | Receive-complete status flag |
| tx_done | input | 1 | Transmit-complete status flag |
| dr_empty | input | 1 | Transmit data register empty flag |
| rx_bit8_in | input | 1 | Received ninth data bit from the receiver |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_tx | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Data-register-empty interrupt request |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| tx_bit8 | output | 1 | Ninth data bit to transmit |
| char_size | output | 3 | Character size code |
| sync_mode | output | 1 | 1 = synchronous operation |
| parity_mode | output | 2 | Parity mode code |
| stop2 | output | 1 | Two stop bits |
| clk_pol | output | 1 | Synchronous clock polarity |
| baud_div | output | 12 | Baud divisor |

## Verification
A write steered to the wrong half of the shared address shows up immediately in two places. The following combinational read of address 1 returns the wrong value under one `hi_sel` setting, and the exported format or divisor outputs change in the cycle after the write edge. A corrupted enable bit is exposed at the interrupt lines one edge after the flag and `gie` are raised. Because every stored bit is readable or exported, no register error can stay hidden for more than one cycle after it is stimulated.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_SHARED = 2'd1,
        REG_DIVLO  = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;

    localparam int BYTE_W   = 8;
    localparam int FMT_W    = 7;
    localparam int N_IRQ    = 3;

    // Bit 7 of a shared-address write chooses the target register.
    localparam int SEL_BIT  = 7;

    // Control bit 1 mirrors the receiver's ninth bit; it is never stored.
    localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hFD;

    // Eight-bit characters, asynchronous, no parity, single stop bit.
    localparam logic [FMT_W-1:0]  FMT_RESET  = 7'b000_0110;

endpackage

// File: rtl/uart_cfg_regfile.sv
module uart_cfg_regfile
    import uart_regs_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        ctrl_q,
    output logic [FMT_W-1:0]         fmt_q,
    output logic [DIV_W-1:0]         div_q
);
    localparam int DIVH_W = DIV_W - BYTE_W;

    logic wr_ctrl, wr_fmt, wr_divh, wr_divl;

    always_comb begin
        wr_ctrl = 1'b0;
        wr_fmt  = 1'b0;
        wr_divh = 1'b0;
        wr_divl = 1'b0;
        if (wr_en) begin
            unique case (reg_addr_e'(addr))
                REG_CTRL:   wr_ctrl = 1'b1;
                REG_SHARED: begin
                    wr_fmt  =  wdata[SEL_BIT];
                    wr_divh = !wdata[SEL_BIT];
                end
                REG_DIVLO:  wr_divl = 1'b1;
                REG_SPARE:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fmt_q  <= FMT_RESET;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & CTRL_WMASK;
            if (wr_fmt)  fmt_q  <= wdata[FMT_W-1:0];
            if (wr_divh) div_q[DIV_W-1:BYTE_W] <= wdata[DIVH_W-1:0];
            if (wr_divl) div_q[BYTE_W-1:0]     <= wdata;
        end
    end

endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
    import uart_regs_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic [1:0]        addr,
    input  logic              hi_sel,
    input  logic              rx_bit8_in,
    input  logic [BYTE_W-1:0] ctrl_q,
    input  logic [FMT_W-1:0]  fmt_q,
    input  logic [DIV_W-1:0]  div_q,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DIVH_W = DIV_W - BYTE_W;
    localparam int PAD_W  = BYTE_W - 1 - DIVH_W;

    logic [BYTE_W-1:0] ctrl_view, fmt_view, divh_view;

    always_comb begin
        ctrl_view = {ctrl_q[7:2], rx_bit8_in, ctrl_q[0]};
        fmt_view  = {1'b1, fmt_q};
        divh_view = {1'b0, {PAD_W{1'b0}}, div_q[DIV_W-1:BYTE_W]};
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_CTRL:   rdata = ctrl_view;
            REG_SHARED: rdata = hi_sel ? divh_view : fmt_view;
            REG_DIVLO:  rdata = div_q[BYTE_W-1:0];
            REG_SPARE:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gie,
    input  logic [N-1:0] ie_vec,
    input  logic [N-1:0] flag_vec,
    output logic [N-1:0] irq_vec
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_vec[i] <= 1'b0;
            else        irq_vec[i] <= gie & ie_vec[i] & flag_vec[i];
        end
    end

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_regs_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             hi_sel,
    output logic [7:0]       rdata,
    input  logic             gie,
    input  logic             rx_done,
    input  logic             tx_done,
    input  logic             dr_empty,
    input  logic             rx_bit8_in,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_dre,
    output logic             rx_en,
    output logic             tx_en,
    output logic             tx_bit8,
    output logic [2:0]       char_size,
    output logic             sync_mode,
    output logic [1:0]       parity_mode,
    output logic             stop2,
    output logic             clk_pol,
    output logic [DIV_W-1:0] baud_div
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [FMT_W-1:0]  fmt_q;
    logic [DIV_W-1:0]  div_q;
    logic [N_IRQ-1:0]  ie_vec, flag_vec, irq_vec;

    uart_cfg_regfile #(.DIV_W(DIV_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .fmt_q  (fmt_q),
        .div_q  (div_q)
    );

    uart_read_mux #(.DIV_W(DIV_W)) u_rmux (
        .addr       (addr),
        .hi_sel     (hi_sel),
        .rx_bit8_in (rx_bit8_in),
        .ctrl_q     (ctrl_q),
        .fmt_q      (fmt_q),
        .div_q      (div_q),
        .rdata      (rdata)
    );

    // Index 2 = receive, 1 = transmit, 0 = empty, matching control bits 7:5.
    assign ie_vec   = ctrl_q[7:5];
    assign flag_vec = {rx_done, tx_done, dr_empty};

    uart_irq_gen #(.N(N_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie      (gie),
        .ie_vec   (ie_vec),
        .flag_vec (flag_vec),
        .irq_vec  (irq_vec)
    );

    assign irq_rx      = irq_vec[2];
    assign irq_tx      = irq_vec[1];
    assign irq_dre     = irq_vec[0];
    assign rx_en       = ctrl_q[4];
    assign tx_en       = ctrl_q[3];
    assign tx_bit8     = ctrl_q[0];
    assign char_size   = {ctrl_q[2], fmt_q[2:1]};
    assign sync_mode   = fmt_q[6];
    assign parity_mode = fmt_q[5:4];
    assign stop2       = fmt_q[3];
    assign clk_pol     = fmt_q[0];
    assign baud_div    = div_q;

endmodule

// File: rtl/uart_ctrl_regs_chk.sv
module uart_ctrl_regs_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [7:0]       wdata,
    input logic             hi_sel,
    input logic [7:0]       rdata,
    input logic             gie,
    input logic [2:0]       ie_vec,
    input logic [2:0]       flag_vec,
    input logic [2:0]       irq_vec,
    input logic [6:0]       fmt_q,
    input logic [DIV_W-1:0] div_q
);
    // R9: each request follows enable, global enable and flag one edge later
    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec == $past(ie_vec & flag_vec & {3{gie}}));

    // R3: a format write leaves the divisor high bits alone
    assert_divh_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[7]) |=> $stable(div_q));

    // R4: a divisor-high write leaves the format alone
    assert_fmt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && !wdata[7]) |=> $stable(fmt_q));

    // R5: the select bit reads back as the inverse of the read source
    assert_shared_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1) |-> (rdata[7] == !hi_sel));

    // R4: reserved divisor bits read as zero
    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1 && hi_sel) |-> (rdata[6:4] == 3'b000));

    // R10: spare address reads zero and a write there changes no register
    assert_spare_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata == 8'h00));
    assert_spare_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> ($stable(div_q) && $stable(fmt_q)));

endmodule

bind uart_ctrl_regs uart_ctrl_regs_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .hi_sel   (hi_sel),
    .rdata    (rdata),
    .gie      (gie),
    .ie_vec   (ie_vec),
    .flag_vec (flag_vec),
    .irq_vec  (irq_vec),
    .fmt_q    (fmt_q),
    .div_q    (div_q)
);

// File: tb/uart_ctrl_regs_bench.sv
`timescale 1ns/1ps
module uart_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic        hi_sel = 1'b0;
    logic [7:0]  rdata;
    logic        gie = 1'b0;
    logic        rx_done = 1'b0, tx_done = 1'b0, dr_empty = 1'b0;
    logic        rx_bit8_in = 1'b0;
    logic        irq_rx, irq_tx, irq_dre;
    logic        rx_en, tx_en, tx_bit8;
    logic [2:0]  char_size;
    logic        sync_mode;
    logic [1:0]  parity_mode;
    logic        stop2, clk_pol;
    logic [11:0] baud_div;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_ctrl_regs u_uart_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hi_sel(hi_sel), .rdata(rdata), .gie(gie), .rx_done(rx_done),
        .tx_done(tx_done), .dr_empty(dr_empty), .rx_bit8_in(rx_bit8_in),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_dre(irq_dre), .rx_en(rx_en),
        .tx_en(tx_en), .tx_bit8(tx_bit8), .char_size(char_size),
        .sync_mode(sync_mode), .parity_mode(parity_mode), .stop2(stop2),
        .clk_pol(clk_pol), .baud_div(baud_div)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic sel, output logic [7:0] d);
        @(negedge clk);
        addr = a; hi_sel = sel;
        #1 d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, 1'b0, d); check("R1 ctrl", d, 8'h00);
        rd(2'd1, 1'b0, d); check("R1 fmt", d, 8'h86);
        rd(2'd1, 1'b1, d); check("R1 divh", d, 8'h00);
        rd(2'd2, 1'b0, d); check("R1 divl", d, 8'h00);
        check("R1 irqs", {irq_rx, irq_tx, irq_dre}, 3'b000);
        check("R1 cfg", {char_size, sync_mode, parity_mode, stop2, clk_pol},
              {3'b011, 1'b0, 2'b00, 1'b0, 1'b0});
        check("R1 div", baud_div, 12'h000);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(2'd0, 8'hFF);
        rd(2'd0, 1'b0, d); check("R2 bit1 ignored", d, 8'hFD);
        check("R2 en outputs", {rx_en, tx_en, tx_bit8}, 3'b111);
        rx_bit8_in = 1'b1;
        rd(2'd0, 1'b0, d); check("R2 live bit8", d, 8'hFF);
        wr(2'd0, 8'h02);
        rx_bit8_in = 1'b0;
        rd(2'd0, 1'b0, d); check("R2 write bit1 only", d, 8'h00);
        check("R2 en cleared", {rx_en, tx_en, tx_bit8}, 3'b000);
    endtask

    task automatic t_shared();
        logic [7:0] d;
        wr(2'd1, 8'hDB);
        rd(2'd1, 1'b0, d); check("R3 fmt write", d, 8'hDB);
        rd(2'd1, 1'b1, d); check("R3 divh kept", d, 8'h00);
        check("R8 fields", {sync_mode, parity_mode, stop2, clk_pol}, {1'b1, 2'b01, 1'b1, 1'b1});
        wr(2'd1, 8'h7A);
        rd(2'd1, 1'b1, d); check("R4 divh write", d, 8'h0A);
        rd(2'd1, 1'b0, d); check("R4 fmt kept", d, 8'hDB);
        check("R5 msb zero on divh", baud_div, 12'hA00);
    endtask

    task automatic t_divlo();
        logic [7:0] d;
        wr(2'd2, 8'h3C);
        rd(2'd2, 1'b0, d); check("R6 divl", d, 8'h3C);
        check("R6 baud_div", baud_div, 12'hA3C);
    endtask

    task automatic t_size();
        wr(2'd0, 8'h04);
        check("R7 size 101", char_size, 3'b101);
        wr(2'd1, 8'h86);
        check("R7 size 111", char_size, 3'b111);
        wr(2'd0, 8'h00);
        check("R7 size 011", char_size, 3'b011);
    endtask

    task automatic t_irq();
        wr(2'd0, 8'hE0);
        @(negedge clk); gie = 1'b1; rx_done = 1'b1;
        @(negedge clk); check("R9 rx only", {irq_rx, irq_tx, irq_dre}, 3'b100);
        rx_done = 1'b0; tx_done = 1'b1;
        @(negedge clk); check("R9 tx only", {irq_rx, irq_tx, irq_dre}, 3'b010);
        tx_done = 1'b0; dr_empty = 1'b1;
        @(negedge clk); check("R9 dre only", {irq_rx, irq_tx, irq_dre}, 3'b001);
        rx_done = 1'b1; tx_done = 1'b1; gie = 1'b0;
        @(negedge clk); check("R9 gie off", {irq_rx, irq_tx, irq_dre}, 3'b000);
        gie = 1'b1;
        @(negedge clk); check("R9 all on", {irq_rx, irq_tx, irq_dre}, 3'b111);
        wr(2'd0, 8'hA0);
        @(negedge clk); check("R9 tx enable off", {irq_rx, irq_tx, irq_dre}, 3'b101);
        gie = 1'b0; rx_done = 1'b0; tx_done = 1'b0; dr_empty = 1'b0;
    endtask

    task automatic t_spare();
        logic [7:0] d;
        wr(2'd3, 8'hFF);
        rd(2'd3, 1'b0, d); check("R10 spare read", d, 8'h00);
        rd(2'd0, 1'b0, d); check("R10 ctrl kept", d, 8'hA0);
        rd(2'd1, 1'b0, d); check("R10 fmt kept", d, 8'h86);
        check("R10 div kept", baud_div, 12'hA3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_shared();
        t_divlo();
        t_size();
        t_irq();
        t_spare();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule